// File: doc/BRIEF.md
# Camera-Control Frame Parser

This block sits behind a bit-recovery stage and turns a stream of recovered bits, each marked by a one-cycle valid strobe, into a decoded pan/tilt/zoom camera command. While idle it hunts for a fixed 8-bit preamble. After the preamble it receives 10-bit characters. Each character holds a start bit of 1, eight data bits sent least-significant first, and a parity bit. The first character is a length byte. Its lower seven bits give how many characters follow, the checksum included.

The characters after the length carry the camera address (low byte, then high byte), an opcode and three argument bytes. The last character is a checksum. A frame ends with the bit pair 0 then 1 where the next start bit would otherwise be. When that pair arrives, the block presents the address, opcode and arguments together with a checksum verdict and pulses a frame-valid strobe. Parity, framing and checksum faults are each reported as a one-cycle pulse. A parity fault does not abort the frame. A framing fault sends the block back to preamble hunting.

Top module: `ptz_frame_parser`

## Requirements
- R1: While hunting, a frame starts only once the last eight valid bits, oldest first, read 1 1 1 1 1 0 1 1. Other bit patterns produce no output activity.
- R2: Every character after the preamble is a start bit of 1, then eight data bits with bit 0 first, then a parity bit.
- R3: Parity is odd over the data byte plus its parity bit. A mismatch pulses `parityError` for one cycle, and the frame is still received to its end and reported with `frameValid`.
- R4: After the length byte, the data bytes are stored in this order: character 1 to `camAddr[7:0]`, character 2 to `camAddr[15:8]`, character 3 to `opcode`, and characters 4 to 6 to `argBytes[7:0]`, `argBytes[15:8]` and `argBytes[23:16]`. Any of these fields that the frame does not carry reads zero.
- R5: The lower seven bits of the length byte give N, the number of characters after it, and character N is the checksum. A length field of zero pulses `framingError` and returns the block to hunting.
- R6: `checksumOk` is 1 when the checksum byte equals the sum, modulo 128, of the length byte and every byte between it and the checksum. When they differ, `checksumError` pulses together with `frameValid`.
- R7: The end pair 0 then 1 makes `frameValid` high for exactly one cycle. `camAddr`, `opcode`, `argBytes` and `checksumOk` change only in that cycle.
- R8: A start bit of 0 where a character is expected, a 1 where the end pair is due, or a second bit of 0 in the end pair each pulse `framingError` and return the block to hunting.
- R9: Bits presented while `bitValid` is low have no effect on decoding.
- R10: After reset all outputs are zero and the block is hunting for a preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Strobe: `bitIn` carries a recovered bit this cycle |
| bitIn | input | 1 | Recovered serial bit |
| camAddr | output | 16 | Camera address of the last completed frame |
| opcode | output | 8 | Opcode of the last completed frame |
| argBytes | output | 24 | Argument bytes; argument 1 in the low byte |
| frameValid | output | 1 | One-cycle pulse when a frame completes |
| checksumOk | output | 1 | Checksum verdict of the last completed frame |
| parityError | output | 1 | One-cycle pulse on a character parity mismatch |
| framingError | output | 1 | One-cycle pulse on a bad start bit, zero length or bad end pair |
| checksumError | output | 1 | One-cycle pulse with `frameValid` when the checksum differs |

## Verification
The assertions assume that `bitValid` is only ever a single-cycle strobe and that `bitIn` matters only while it is high. They therefore check that the decoder phase is frozen whenever no strobe is present. The stimulus respects this: each bit is a single strobe, and the cycles between strobes carry inverted junk on `bitIn`. The assertions also assume that the result fields move only with a frame-complete pulse. The directed tests reach that pulse through full frames, short frames, and frames with bad parity or a bad checksum. They also drive aborted frames, so the error paths are exercised without ever breaking the strobe discipline.

// File: rtl/ptz_frame_pkg.sv
package ptz_frame_pkg;

  localparam int IDX_W = 8;
  localparam int LEN_W = 7;

  typedef enum logic [2:0] {
    PH_HUNT,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_END
  } phase_t;

  typedef struct packed {
    logic             preShift;
    logic             preClear;
    logic             dataShift;
    logic             frameStart;
    logic             byteDone;
    logic             isLast;
    logic [IDX_W-1:0] byteIdx;
    logic             commit;
    logic             framingErr;
  } ctrl_t;

endpackage

// File: rtl/ptz_frame_ctrl.sv
module ptz_frame_ctrl
  import ptz_frame_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             preHit,
  input  logic [LEN_W-1:0] curLen,
  input  logic [LEN_W-1:0] lenReg,
  output ctrl_t            ctl
);

  localparam int CNT_W = $clog2(DATA_W);

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic [IDX_W-1:0] byteCnt, byteCntNext;
  logic             endDue, lastChar;

  assign endDue   = (byteCnt != '0) && (byteCnt == ({1'b0, lenReg} + IDX_W'(1)));
  assign lastChar = (byteCnt != '0) && (byteCnt == {1'b0, lenReg});

  always_comb begin
    ctl         = '0;
    phaseNext   = phase;
    bitCntNext  = bitCnt;
    byteCntNext = byteCnt;
    if (bitValid) begin
      unique case (phase)
        PH_HUNT: begin
          ctl.preShift = 1'b1;
          if (preHit) begin
            ctl.frameStart = 1'b1;
            ctl.preClear   = 1'b1;
            byteCntNext    = '0;
            phaseNext      = PH_START;
          end
        end
        PH_START: begin
          if (endDue) begin
            if (bitIn) begin
              ctl.framingErr = 1'b1;
              ctl.preClear   = 1'b1;
              phaseNext      = PH_HUNT;
            end else begin
              phaseNext = PH_END;
            end
          end else if (bitIn) begin
            bitCntNext = '0;
            phaseNext  = PH_DATA;
          end else begin
            ctl.framingErr = 1'b1;
            ctl.preClear   = 1'b1;
            phaseNext      = PH_HUNT;
          end
        end
        PH_DATA: begin
          ctl.dataShift = 1'b1;
          bitCntNext    = bitCnt + CNT_W'(1);
          if (bitCnt == CNT_W'(DATA_W - 1)) phaseNext = PH_PAR;
        end
        PH_PAR: begin
          ctl.byteDone = 1'b1;
          ctl.byteIdx  = byteCnt;
          ctl.isLast   = lastChar;
          if ((byteCnt == '0) && (curLen == '0)) begin
            ctl.framingErr = 1'b1;
            ctl.preClear   = 1'b1;
            phaseNext      = PH_HUNT;
          end else begin
            byteCntNext = byteCnt + IDX_W'(1);
            phaseNext   = PH_START;
          end
        end
        PH_END: begin
          ctl.preClear = 1'b1;
          if (bitIn) ctl.commit = 1'b1;
          else       ctl.framingErr = 1'b1;
          phaseNext = PH_HUNT;
        end
        default: phaseNext = PH_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_HUNT;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else begin
      phase   <= phaseNext;
      bitCnt  <= bitCntNext;
      byteCnt <= byteCntNext;
    end
  end

  // R9: no strobe, no movement of the decoder phase
  a_r9_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !bitValid |=> $stable(phase));

  // R8: every framing fault lands the decoder back in preamble hunting
  a_r8_fault_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.framingErr |=> (phase == PH_HUNT));

endmodule

// File: rtl/ptz_frame_dp.sv
module ptz_frame_dp
  import ptz_frame_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ARG_N    = 3,
  parameter logic [7:0]  PREAMBLE = 8'hFB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bitIn,
  input  ctrl_t                   ctl,
  output logic                    preHit,
  output logic [LEN_W-1:0]        curLen,
  output logic [LEN_W-1:0]        lenReg,
  output logic [2*DATA_W-1:0]     camAddr,
  output logic [DATA_W-1:0]       opcode,
  output logic [ARG_N*DATA_W-1:0] argBytes,
  output logic                    frameValid,
  output logic                    checksumOk,
  output logic                    parityError,
  output logic                    framingError,
  output logic                    checksumError
);

  localparam int FIELD_N = 3 + ARG_N;

  logic [DATA_W-1:0]              preSr;
  logic [DATA_W-1:0]              dataSr;
  logic [LEN_W-1:0]               sumAcc;
  logic                           cksGood;
  logic [FIELD_N-1:0][DATA_W-1:0] stage;
  logic [FIELD_N-1:0][DATA_W-1:0] held;

  assign preHit = ({preSr[DATA_W-2:0], bitIn} == PREAMBLE);
  assign curLen = dataSr[LEN_W-1:0];

  // preamble window and character shifter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preSr  <= '0;
      dataSr <= '0;
    end else begin
      if (ctl.preClear)      preSr <= '0;
      else if (ctl.preShift) preSr <= {preSr[DATA_W-2:0], bitIn};
      if (ctl.dataShift)     dataSr <= {bitIn, dataSr[DATA_W-1:1]};
    end
  end

  // length, running sum, checksum verdict and field staging
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lenReg  <= '0;
      sumAcc  <= '0;
      cksGood <= 1'b0;
      stage   <= '0;
    end else if (ctl.frameStart) begin
      lenReg  <= '0;
      sumAcc  <= '0;
      cksGood <= 1'b0;
      stage   <= '0;
    end else if (ctl.byteDone) begin
      if (ctl.byteIdx == '0) lenReg <= dataSr[LEN_W-1:0];
      if (ctl.isLast) begin
        cksGood <= (dataSr == DATA_W'(sumAcc));
      end else begin
        sumAcc <= sumAcc + dataSr[LEN_W-1:0];
        for (int k = 0; k < FIELD_N; k++) begin
          if (ctl.byteIdx == IDX_W'(k + 1)) stage[k] <= dataSr;
        end
      end
    end
  end

  // result registers and pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held          <= '0;
      checksumOk    <= 1'b0;
      frameValid    <= 1'b0;
      parityError   <= 1'b0;
      framingError  <= 1'b0;
      checksumError <= 1'b0;
    end else begin
      frameValid    <= ctl.commit;
      framingError  <= ctl.framingErr;
      parityError   <= ctl.byteDone && !(^{dataSr, bitIn});
      checksumError <= ctl.commit && !cksGood;
      if (ctl.commit) begin
        held       <= stage;
        checksumOk <= cksGood;
      end
    end
  end

  assign camAddr = {held[1], held[0]};
  assign opcode  = held[2];

  for (genvar j = 0; j < ARG_N; j++) begin : g_arg
    assign argBytes[j*DATA_W +: DATA_W] = held[3 + j];
  end

  // R7: result fields move only in the frame-complete cycle
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frameValid |-> $stable({camAddr, opcode, argBytes, checksumOk}));

  // R6: a checksum fault is reported only on a completed, failing frame
  a_r6_cks_err_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    checksumError |-> (frameValid && !checksumOk));

  // R7 / R8: completion and framing fault never coincide
  a_r7_done_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |-> !framingError);

endmodule

// File: rtl/ptz_frame_parser.sv
module ptz_frame_parser
  import ptz_frame_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         ARG_N    = 3,
  parameter logic [7:0] PREAMBLE = 8'hFB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bitValid,
  input  logic                    bitIn,
  output logic [2*DATA_W-1:0]     camAddr,
  output logic [DATA_W-1:0]       opcode,
  output logic [ARG_N*DATA_W-1:0] argBytes,
  output logic                    frameValid,
  output logic                    checksumOk,
  output logic                    parityError,
  output logic                    framingError,
  output logic                    checksumError
);

  ctrl_t            ctl;
  logic             preHit;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] lenReg;

  ptz_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .bitValid(bitValid),
    .bitIn   (bitIn),
    .preHit  (preHit),
    .curLen  (curLen),
    .lenReg  (lenReg),
    .ctl     (ctl)
  );

  ptz_frame_dp #(.DATA_W(DATA_W), .ARG_N(ARG_N), .PREAMBLE(PREAMBLE)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .bitIn        (bitIn),
    .ctl          (ctl),
    .preHit       (preHit),
    .curLen       (curLen),
    .lenReg       (lenReg),
    .camAddr      (camAddr),
    .opcode       (opcode),
    .argBytes     (argBytes),
    .frameValid   (frameValid),
    .checksumOk   (checksumOk),
    .parityError  (parityError),
    .framingError (framingError),
    .checksumError(checksumError)
  );

  // R1 / R8: pulses only follow an accepted bit
  a_r1_pulse_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (frameValid || framingError) |-> $past(bitValid));

endmodule

// File: tb/ptz_frame_parser_tb.sv
module ptz_frame_parser_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [15:0] camAddr;
  logic [7:0]  opcode;
  logic [23:0] argBytes;
  logic        frameValid, checksumOk, parityError, framingError, checksumError;

  int total = 0;
  int bad = 0;
  int gap = 0;
  logic sawFv, sawPar, sawFram, sawCks;

  always #4 clk = ~clk;

  ptz_frame_parser u_dut (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .camAddr(camAddr), .opcode(opcode), .argBytes(argBytes),
    .frameValid(frameValid), .checksumOk(checksumOk),
    .parityError(parityError), .framingError(framingError),
    .checksumError(checksumError)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic capture();
    sawFv   |= frameValid;
    sawPar  |= parityError;
    sawFram |= framingError;
    sawCks  |= checksumError;
  endtask

  task automatic clearSaw();
    sawFv = 0; sawPar = 0; sawFram = 0; sawCks = 0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitIn = b; bitValid = 1'b1;
    @(negedge clk); bitValid = 1'b0; capture();
    for (int g = 0; g < gap; g++) begin
      bitIn = ~b;
      @(negedge clk); capture();
    end
  endtask

  task automatic sendChar(input logic [7:0] b, input logic flip);
    sendBit(1'b1);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    sendBit((~^b) ^ flip);
  endtask

  task automatic sendPre();
    sendBit(1); sendBit(1); sendBit(1); sendBit(1);
    sendBit(1); sendBit(0); sendBit(1); sendBit(1);
  endtask

  task automatic sendEnd();
    sendBit(1'b0); sendBit(1'b1);
  endtask

  function automatic logic [7:0] cks(input logic [7:0] l, a0, a1, op, g1, g2, g3);
    logic [7:0] s;
    s = l + a0 + a1 + op + g1 + g2 + g3;
    return {1'b0, s[6:0]};
  endfunction

  task automatic sendFrame(input logic [15:0] addr, input logic [7:0] op, g1, g2, g3,
                           input logic flipOpPar, input logic [7:0] cksXor);
    sendPre();
    sendChar(8'h87, 0);
    sendChar(addr[7:0], 0);
    sendChar(addr[15:8], 0);
    sendChar(op, flipOpPar);
    sendChar(g1, 0);
    sendChar(g2, 0);
    sendChar(g3, 0);
    sendChar(cks(8'h87, addr[7:0], addr[15:8], op, g1, g2, g3) ^ cksXor, 0);
  endtask

  task automatic checkFields(input string tag, input logic [15:0] addr, input logic [7:0] op,
                             input logic [23:0] args);
    check({tag, " camAddr"}, 32'(camAddr), 32'(addr));
    check({tag, " opcode"}, 32'(opcode), 32'(op));
    check({tag, " argBytes"}, 32'(argBytes), 32'(args));
  endtask

  task automatic testReset();
    check("R10 frameValid", 32'(frameValid), 0);
    check("R10 checksumOk", 32'(checksumOk), 0);
    check("R10 errors", 32'({parityError, framingError, checksumError}), 0);
    checkFields("R10", 16'h0, 8'h0, 24'h0);
  endtask

  task automatic testZoom();
    clearSaw();
    sendBit(0); sendBit(1); sendBit(0); sendBit(0); sendBit(1); sendBit(1); sendBit(0);
    check("R1 noise gives no pulse", 32'({sawFv, sawFram}), 0);
    sendFrame(16'h0000, 8'h05, 8'h10, 8'h00, 8'h20, 0, 8'h00);
    sendEnd();
    check("R7 frameValid pulse", 32'(sawFv), 1);
    check("R6 checksumOk zoom", 32'(checksumOk), 1);
    check("R3 no parity error", 32'({sawPar, sawFram, sawCks}), 0);
    checkFields("R4 zoom", 16'h0000, 8'h05, 24'h200010);
  endtask

  task automatic testHoldAndGap();
    clearSaw();
    gap = 3;
    sendFrame(16'hA53C, 8'h07, 8'h81, 8'h7E, 8'h02, 0, 8'h00);
    check("R7 hold before end", 32'(sawFv), 0);
    checkFields("R7 hold", 16'h0000, 8'h05, 24'h200010);
    sendEnd();
    gap = 0;
    check("R9 gapped frame completes", 32'(sawFv), 1);
    checkFields("R2 R9 gapped", 16'hA53C, 8'h07, 24'h027E81);
    check("R6 checksumOk gapped", 32'(checksumOk), 1);
  endtask

  task automatic testParity();
    clearSaw();
    sendFrame(16'h1234, 8'h22, 8'h01, 8'h02, 8'h03, 1, 8'h00);
    check("R3 parity pulse", 32'(sawPar), 1);
    sendEnd();
    check("R3 frame still done", 32'(sawFv), 1);
    checkFields("R3", 16'h1234, 8'h22, 24'h030201);
  endtask

  task automatic testChecksum();
    clearSaw();
    sendFrame(16'h0042, 8'h11, 8'h00, 8'h00, 8'h00, 0, 8'h01);
    sendEnd();
    check("R6 checksum error pulse", 32'({sawFv, sawCks}), 32'h3);
    check("R6 checksumOk low", 32'(checksumOk), 0);
    check("R6 fields still taken", 32'(opcode), 32'h11);
  endtask

  task automatic testShort();
    logic [7:0] c;
    clearSaw();
    c = (8'h83 + 8'h34 + 8'h12) & 8'h7F;
    sendPre();
    sendChar(8'h83, 0); sendChar(8'h34, 0); sendChar(8'h12, 0); sendChar(c, 0);
    sendEnd();
    check("R5 short frame done", 32'(sawFv), 1);
    checkFields("R5 R4 short", 16'h1234, 8'h00, 24'h0);
    check("R5 short checksumOk", 32'(checksumOk), 1);
  endtask

  task automatic testFraming();
    clearSaw();
    sendPre(); sendChar(8'h87, 0); sendBit(0);
    check("R8 start zero", 32'(sawFram), 1);
    clearSaw();
    sendPre(); sendChar(8'h80, 0);
    check("R5 zero length", 32'(sawFram), 1);
    clearSaw();
    sendFrame(16'h0001, 8'h01, 8'h01, 8'h01, 8'h01, 0, 8'h00);
    sendBit(1);
    check("R8 extra start bit", 32'({sawFv, sawFram}), 1);
    clearSaw();
    sendFrame(16'h0002, 8'h02, 8'h02, 8'h02, 8'h02, 0, 8'h00);
    sendBit(0); sendBit(0);
    check("R8 bad end pair", 32'({sawFv, sawFram}), 1);
    checkFields("R8 no update", 16'h1234, 8'h00, 24'h0);
    clearSaw();
    sendFrame(16'hBEEF, 8'h05, 8'h10, 8'h00, 8'h40, 0, 8'h00);
    sendEnd();
    check("R1 recovery", 32'({sawFv, sawFram}), 32'h2);
    checkFields("R1 recovery", 16'hBEEF, 8'h05, 24'h400010);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testZoom();
    testHoldAndGap();
    testParity();
    testChecksum();
    testShort();
    testFraming();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule